// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Mux

This block sits in the scan-out path of a frame buffer that mixes two colour depths on one screen. Each incoming pixel carries three words: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word picks the pixel's source, pixel by pixel. One code value selects the direct colour. Every other value selects the palette entry named by the index.

The block accepts pixels on a valid/ready stream. For indexed pixels it issues a read on an external palette port, which returns the entry one cycle later. It delivers 24-bit RGB, red in the top byte, on a second valid/ready stream. Direct words hold their components blue-lowest-address first, so the block reverses the byte order. An end-of-line flag travels with each pixel. Lines are 1024 pixels long, and the flag is carried rather than generated. Back-pressure from the output stalls the input without losing or repeating pixels.

Top module: `pxmux_direct_idx`

## Requirements
- R1: After reset, and after any reset asserted in the middle of a stream, out_valid is 0 and in_ready is 1 until a pixel is accepted.
- R2: A pixel whose control word bits 31:24 equal 0x03 is output as direct colour: out_rgb = {direct[7:0], direct[15:8], direct[23:16]}. Bits 31:24 of the direct word are ignored.
- R3: A pixel with any other control code is output as the palette entry at its index. The block raises pal_rd_en with pal_addr equal to in_index in the accepting cycle. The entry is taken from pal_rgb one cycle later. Direct pixels do not raise pal_rd_en.
- R4: Only control bits 31:24 decide the path. Codes 0x00, 0x02, 0x13, 0x83 and 0xFF select the palette, and control bits 23:0 have no effect.
- R5: Pixels leave in the order they enter. With out_ready held high, a pixel accepted at one clock edge is presented on the output after the second edge.
- R6: While out_valid is 1 and out_ready is 0, the output holds: out_valid stays 1, and out_rgb and out_eol do not change.
- R7: Under any out_ready pattern, every accepted pixel is output exactly once, and at most two pixels are held inside.
- R8: out_eol equals the in_eol given with the same pixel.
- R9: An indexed pixel keeps its palette colour even when the output stalls and pal_rgb changes after the read cycle.
- R10: With out_ready held high, in_ready stays high and one pixel passes per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_index | input | 8 | Palette index of the pixel |
| in_direct | input | 32 | Direct-colour word, blue in bits 23:16, red in bits 7:0 |
| in_ctrl | input | 32 | Control word; bits 31:24 hold the source code |
| in_eol | input | 1 | Last pixel of the line |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_addr | output | 8 | Palette read address |
| pal_rgb | input | 24 | Palette entry, valid the cycle after pal_rd_en |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_rgb | output | 24 | Pixel colour, red 23:16, green 15:8, blue 7:0 |
| out_eol | output | 1 | End-of-line flag of the output pixel |

## Verification
The bench builds the block with its default parameters: 8-bit index, 32-bit words, 8-bit components and direct code 0x03. With these values every control code used in the requirements, and byte-exact component swaps, can be driven directly. The bench palette returns a junk value in any cycle without a read strobe. A stalled indexed pixel therefore shows at once whether its entry was captured. One pass with a free-running consumer exposes the two-cycle latency and full rate. A pass with an irregular out_ready exposes hold, ordering and loss under back-pressure.

// File: rtl/pxmux_direct_idx.sv
module pxmux_direct_idx #(
  parameter int IDX_W       = 8,
  parameter int WORD_W      = 32,
  parameter int COMP_W      = 8,
  parameter int CODE_W      = 8,
  parameter logic [CODE_W-1:0] DIRECT_CODE = 8'h03
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IDX_W-1:0]    in_index,
  input  logic [WORD_W-1:0]   in_direct,
  input  logic [WORD_W-1:0]   in_ctrl,
  input  logic                in_eol,
  output logic                pal_rd_en,
  output logic [IDX_W-1:0]    pal_addr,
  input  logic [3*COMP_W-1:0] pal_rgb,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [3*COMP_W-1:0] out_rgb,
  output logic                out_eol
);
  localparam int RGB_W = 3 * COMP_W;

  logic              s1_v, s1_direct, s1_eol, s1_fresh;
  logic [RGB_W-1:0]  s1_rgb_d, s1_pal, s1_colour, swapped;
  logic              s2_v, s2_eol;
  logic [RGB_W-1:0]  s2_rgb;
  logic              s2_take, s1_go, accept, is_direct;

  for (genvar k = 0; k < 3; k++) begin : g_swap
    assign swapped[k*COMP_W +: COMP_W] = in_direct[(2-k)*COMP_W +: COMP_W];
  end

  assign is_direct = in_ctrl[WORD_W-1 -: CODE_W] == DIRECT_CODE;
  assign s2_take   = !s2_v || out_ready;
  assign s1_go     = s1_v && s2_take;
  assign in_ready  = !s1_v || s2_take;
  assign accept    = in_valid && in_ready;
  assign pal_rd_en = accept && !is_direct;
  assign pal_addr  = in_index;
  assign s1_colour = s1_direct ? s1_rgb_d : (s1_fresh ? pal_rgb : s1_pal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_fresh <= 1'b0;
    end else begin
      if (s1_v && s1_fresh && !s1_go) s1_fresh <= 1'b0;
      if (accept) begin
        s1_v     <= 1'b1;
        s1_fresh <= !is_direct;
      end else if (s1_go) begin
        s1_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_direct <= is_direct;
      s1_eol    <= in_eol;
      s1_rgb_d  <= swapped;
    end
    if (s1_v && s1_fresh && !s1_go) s1_pal <= pal_rgb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_v <= 1'b0;
    else if (s2_take) s2_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (s1_go) begin
      s2_rgb <= s1_colour;
      s2_eol <= s1_eol;
    end
  end

  assign out_valid = s2_v;
  assign out_rgb   = s2_rgb;
  assign out_eol   = s2_eol;
endmodule

module pxmux_direct_idx_chk #(
  parameter int RGB_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             pal_rd_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RGB_W-1:0] out_rgb,
  input logic             out_eol
);
  logic [1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 2'((in_valid && in_ready) ? 1 : 0)
                              - 2'((out_valid && out_ready) ? 1 : 0);
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));
  assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_en |-> (in_valid && in_ready));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_eol)));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 2'd2);
  assert_no_phantom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 2'd0);
  assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == 2'd0) |-> in_ready);
endmodule

bind pxmux_direct_idx pxmux_direct_idx_chk #(.RGB_W(RGB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .pal_rd_en(pal_rd_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_rgb(out_rgb), .out_eol(out_eol));

// File: tb/sim_pxmux_direct_idx.sv
`timescale 1ns/1ps
module sim_pxmux_direct_idx;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_eol = 0, pal_rd_en, out_valid, out_ready = 0, out_eol;
  logic [7:0] in_index = 0, pal_addr;
  logic [31:0] in_direct = 0, in_ctrl = 0;
  logic [23:0] pal_rgb, out_rgb;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pxmux_direct_idx u0 (.*);

  function automatic logic [23:0] pal_f(input logic [7:0] a);
    return {a, ~a, a ^ 8'hA5};
  endfunction

  always_ff @(posedge clk) pal_rgb <= pal_rd_en ? pal_f(pal_addr) : 24'hBAD0BA;

  localparam int N = 9;
  // {eol, ctrl, direct, index, expected}
  localparam logic [96:0] TAB [N] = '{
    {1'b0, 32'h03000000, 32'hFF112233, 8'h00, 24'h332211},
    {1'b0, 32'h03ABCDEF, 32'h00A0B0C0, 8'h44, 24'hC0B0A0},
    {1'b0, 32'h00000000, 32'h03FFFFFF, 8'h10, 24'h10EFB5},
    {1'b0, 32'h02000000, 32'h00000000, 8'hFF, 24'hFF005A},
    {1'b0, 32'h83000000, 32'h12345678, 8'h01, 24'h01FEA4},
    {1'b1, 32'h13000000, 32'h00000000, 8'h80, 24'h807F25},
    {1'b0, 32'h0300FFFF, 32'h7E000001, 8'h22, 24'h010000},
    {1'b0, 32'hFF000003, 32'h00000000, 8'h5A, 24'h5AA5FF},
    {1'b1, 32'h03000000, 32'h00FFFFFF, 8'h00, 24'hFFFFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_table(input bit stall);
    int s = 0, r = 0, it = 0;
    bit was_stall = 0;
    logic [23:0] held = 0;
    while (r < N && it < 400) begin
      @(negedge clk);
      out_ready = stall ? ((it % 3) != 1 && it > 3) : 1'b1;
      in_valid  = s < N;
      if (s < N) {in_eol, in_ctrl, in_direct, in_index} = TAB[s][96:24];
      #1;
      if (was_stall) chk(out_valid && out_rgb == held, "R6 hold", {7'd0, out_valid, out_rgb}, {8'h01, held});
      was_stall = out_valid && !out_ready;
      held = out_rgb;
      if (!stall && s < N) chk(in_ready, "R10 ready", 32'(in_ready), 1);
      if (in_valid && in_ready) begin
        if (TAB[s][95:88] == 8'h03)
          chk(!pal_rd_en, "R3 no read on direct", 32'(pal_rd_en), 0);
        else
          chk(pal_rd_en && pal_addr == TAB[s][31:24], "R3 read strobe", {23'd0, pal_rd_en, pal_addr}, {24'd1, TAB[s][31:24]});
      end
      if (out_valid && out_ready) begin
        if (r < N) begin
          chk(out_rgb == TAB[r][23:0], "R2/R4/R5 colour", 32'(out_rgb), 32'(TAB[r][23:0]));
          chk(out_eol == TAB[r][96], "R8 eol", 32'(out_eol), 32'(TAB[r][96]));
        end
        r++;
      end
      if (in_valid && in_ready) s++;
      it++;
    end
    if (!stall) chk(it == N + 2, "R5/R10 latency and rate", it, N + 2);
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(!out_valid, "R7 no duplicate", 32'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #1;
    chk(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 2'b01);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);
    run_table(0);
    run_table(1);
    // R9: indexed pixel stalled while palette port changes
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_ctrl = 32'h01000000; in_index = 8'h33; in_eol = 1;
    @(negedge clk);
    in_valid = 0;
    repeat (5) @(negedge clk);
    #1;
    chk(out_valid && out_rgb == pal_f(8'h33), "R9 captured entry", 32'(out_rgb), 32'(pal_f(8'h33)));
    chk(out_eol, "R8 eol stalled", 32'(out_eol), 1);
    @(negedge clk);
    out_ready = 1;
    @(negedge clk);
    #1;
    chk(!out_valid, "R7 single output", 32'(out_valid), 0);
    // R1: reset mid-stream
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_ctrl = 32'h03000000;
    repeat (3) @(negedge clk);
    in_valid = 0; rst_n = 0;
    #1;
    chk(!out_valid && in_ready, "R1 mid-stream reset", {out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(!out_valid && in_ready, "R1 after mid reset", {out_valid, in_ready}, 2'b01);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 20000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected less", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule